// File: doc/BRIEF.md
# SONET Overhead Tap with Descrambler and B1 Monitor

This block sits behind a frame aligner on a byte-wide SONET/SDH receive path. It takes one byte per clock, a marker that flags the first framing byte of each frame and an out-of-frame flag. From these it keeps its own row and column position inside a frame of `N_STS` byte-interleaved STS-1 signals. It removes the frame-synchronous scrambling from the stream. A control input can turn that step off.

Two results leave the block. First, it recomputes section parity (BIP-8) over each received frame and compares that value with the parity byte carried in the next frame. Each differing bit position produces one pulse on `b1_err`. Second, it copies the nine rows of three transport overhead bytes that belong to the first STS-1 onto an 8-bit bus. Each copied byte comes with a one-cycle strobe, and a frame marker flags the first of the 27. While the aligner reports out-of-frame, both functions are held off.

Top module: `sonet_oh_tap`

## Requirements
- R1: While `rst` is high and on the cycle after it is released, `oh_stb`, `oh_fp` and `b1_err` are low.
- R2: A byte that arrives with `rx_frame_start` high is row 0, column 0, and a row is 90·`N_STS` bytes long. The bytes at columns 0, `N_STS` and 2·`N_STS` of each of the 9 rows appear on `oh_data`, one clock after they arrive. That gives 27 one-cycle `oh_stb` pulses per frame, in row order.
- R3: `oh_fp` is high exactly once per frame, together with the strobe of the row-0, column-0 byte.
- R4: Descrambling XORs each byte with a key taken from a 7-bit generator for x^7+x^6+1. The key's first bit goes to bit 7 of the byte. The generator is loaded with all ones at row 0, column 3·`N_STS`, so that byte's key is 0xFE. The row-0 bytes in columns 0 to 3·`N_STS`−1 pass through unchanged.
- R5: With `descr_off` high, every byte is used exactly as received.
- R6: Even BIP-8 is taken over all received, still-scrambled bytes of a frame. It is compared with the descrambled byte at row 1, column 0 of the next frame. k differing bits give exactly k pulses on `b1_err`, each pulse high for one cycle with at least one low cycle between pulses. A match gives no pulse.
- R7: The first error pulse rises 90·`N_STS`+1 cycles after the `oh_fp` of the same frame.
- R8: The parity byte is not checked in the first frame after frame alignment is gained, and is not checked after a frame during which out-of-frame was reported.
- R9: While `rx_oof` is high, and until the next `rx_frame_start`, no `oh_stb` is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Byte clock |
| rst | input | 1 | Synchronous reset, active high |
| rx_byte | input | 8 | Received (scrambled) byte |
| rx_frame_start | input | 1 | High with the first framing byte of a frame |
| rx_oof | input | 1 | Aligner reports out-of-frame |
| descr_off | input | 1 | Bypass the descrambler |
| oh_data | output | 8 | Exported overhead byte of the first STS-1 |
| oh_stb | output | 1 | One-cycle strobe for `oh_data` |
| oh_fp | output | 1 | Marks the strobe of the first framing byte |
| b1_err | output | 1 | Parity error pulse train |

## Verification
The bench builds the block with `N_STS` = 2. At that setting the three first-STS-1 overhead columns sit two bytes apart (columns 0, 2 and 4). A design that ignores the interleave stride therefore exports the wrong bytes. A frame is still only 1620 cycles long, so a run of a dozen frames fits easily. The descrambler seed point is at column 6 and the parity byte at index 180. Error pulse delays of 181 cycles and up to eight-pulse trains can all be observed within one frame.

// File: rtl/sonet_oh_tap_pkg.sv
package sonet_oh_tap_pkg;

    localparam int ROWS          = 9;
    localparam int COLS_PER_STS  = 90;
    localparam int TOH_PER_STS   = 3;
    localparam int LFSR_W        = 7;
    localparam logic [LFSR_W-1:0] LFSR_SEED = '1;

    // Position flags of the byte currently on the input.
    typedef struct packed {
        logic frame_first;  // row 0, column 0
        logic tap;          // first-STS-1 overhead column
        logic clear_zone;   // row-0 overhead that is never scrambled
        logic seed_pt;      // generator is reloaded here
        logic b1_pos;       // parity byte position (row 1, column 0)
        logic on_schedule;  // frame start reached by counting, while aligned
    } pos_info_t;

    typedef struct packed {
        logic [7:0]        key;
        logic [LFSR_W-1:0] next;
    } key_step_t;

    // Eight steps of x^7+x^6+1; the first output bit lands in bit 7.
    function automatic key_step_t lfsr_byte(input logic [LFSR_W-1:0] st);
        key_step_t         r;
        logic [LFSR_W-1:0] s;
        s = st;
        r.key = '0;
        for (int i = 0; i < 8; i++) begin
            r.key[7-i] = s[LFSR_W-1];
            s = {s[LFSR_W-2:0], s[LFSR_W-1] ^ s[LFSR_W-2]};
        end
        r.next = s;
        return r;
    endfunction

    function automatic logic [3:0] ones8(input logic [7:0] v);
        logic [3:0] n;
        n = '0;
        for (int i = 0; i < 8; i++) n = n + {3'b000, v[i]};
        return n;
    endfunction

endpackage

// File: rtl/soht_position.sv
module soht_position
    import sonet_oh_tap_pkg::*;
#(
    parameter int N_STS = 3
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      frm_start,
    input  logic      oof,
    output pos_info_t info,
    output logic      active
);
    localparam int ROWLEN = COLS_PER_STS * N_STS;
    localparam int COL_W  = $clog2(ROWLEN);
    localparam int ROW_W  = $clog2(ROWS);
    localparam int TOHLEN = TOH_PER_STS * N_STS;

    logic [COL_W-1:0] col_q, cur_col;
    logic [ROW_W-1:0] row_q, cur_row;
    logic             locked_q;

    always_comb begin
        cur_col = frm_start ? '0 : col_q;
        cur_row = frm_start ? '0 : row_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            col_q    <= '0;
            row_q    <= '0;
            locked_q <= 1'b0;
        end else begin
            if (cur_col == COL_W'(ROWLEN-1)) begin
                col_q <= '0;
                row_q <= (cur_row == ROW_W'(ROWS-1)) ? '0 : cur_row + 1'b1;
            end else begin
                col_q <= cur_col + 1'b1;
                row_q <= cur_row;
            end
            if (oof)            locked_q <= 1'b0;
            else if (frm_start) locked_q <= 1'b1;
        end
    end

    always_comb begin
        active           = !oof && (locked_q || frm_start);
        info.frame_first = (cur_row == '0) && (cur_col == '0);
        info.tap         = (cur_col == '0) || (cur_col == COL_W'(N_STS))
                        || (cur_col == COL_W'(2*N_STS));
        info.clear_zone  = (cur_row == '0) && (cur_col < COL_W'(TOHLEN));
        info.seed_pt     = (cur_row == '0) && (cur_col == COL_W'(TOHLEN));
        info.b1_pos      = (cur_row == ROW_W'(1)) && (cur_col == '0);
        info.on_schedule = locked_q && (col_q == '0) && (row_q == '0);
    end

    // R2: the position counters stay inside one frame.
    a_r2_col_bounded: assert property (@(posedge clk) disable iff (rst)
        col_q <= COL_W'(ROWLEN-1));
    a_r2_row_bounded: assert property (@(posedge clk) disable iff (rst)
        row_q <= ROW_W'(ROWS-1));
    // R9: out-of-frame drops alignment on the next cycle.
    a_r9_unlock: assert property (@(posedge clk) disable iff (rst)
        oof |=> !locked_q);
endmodule

// File: rtl/soht_descrambler.sv
module soht_descrambler
    import sonet_oh_tap_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic [7:0] din,
    input  pos_info_t info,
    input  logic      bypass,
    output logic [7:0] dout
);
    logic [LFSR_W-1:0] st_q, cur_st;
    key_step_t         step;

    always_comb begin
        cur_st = info.seed_pt ? LFSR_SEED : st_q;
        step   = lfsr_byte(cur_st);
        dout   = (bypass || info.clear_zone) ? din : (din ^ step.key);
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= LFSR_SEED;
        else     st_q <= step.next;
    end

    // R4: eight steps past the all-ones load leave state 0000010.
    a_r4_seed_advance: assert property (@(posedge clk) disable iff (rst)
        info.seed_pt |=> (st_q == 7'h02));
    // R4: the generator never falls into the all-zero lock-up state.
    a_r4_no_lockup: assert property (@(posedge clk) disable iff (rst)
        st_q != '0);
endmodule

// File: rtl/soht_bip8.sv
module soht_bip8
    import sonet_oh_tap_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic [7:0] raw,
    input  logic [7:0] plain,
    input  pos_info_t info,
    input  logic      active,
    output logic      err_pulse
);
    logic [7:0] acc_q, prev_q;
    logic       acc_full_q, prev_ok_q;
    logic [3:0] pend_q;
    logic       load;

    assign load = active && info.b1_pos && prev_ok_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q      <= '0;
            prev_q     <= '0;
            acc_full_q <= 1'b0;
            prev_ok_q  <= 1'b0;
        end else if (!active) begin
            acc_full_q <= 1'b0;
            prev_ok_q  <= 1'b0;
        end else if (info.frame_first) begin
            prev_q     <= acc_q;
            prev_ok_q  <= acc_full_q && info.on_schedule;
            acc_q      <= raw;
            acc_full_q <= 1'b1;
        end else begin
            acc_q <= acc_q ^ raw;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q    <= '0;
            err_pulse <= 1'b0;
        end else begin
            err_pulse <= 1'b0;
            if (load) begin
                pend_q <= ones8(prev_q ^ plain);
            end else if (pend_q != '0 && !err_pulse) begin
                err_pulse <= 1'b1;
                pend_q    <= pend_q - 1'b1;
            end
        end
    end

    // R6: every pulse is one cycle wide.
    a_r6_single_cycle: assert property (@(posedge clk) disable iff (rst)
        err_pulse |=> !err_pulse);
    // R6: a pulse is only issued from a pending count.
    a_r6_from_count: assert property (@(posedge clk) disable iff (rst)
        $rose(err_pulse) |-> ($past(pend_q) != '0));
    a_r6_count_bound: assert property (@(posedge clk) disable iff (rst)
        pend_q <= 4'd8);
endmodule

// File: rtl/sonet_oh_tap.sv
module sonet_oh_tap
    import sonet_oh_tap_pkg::*;
#(
    parameter int N_STS = 3
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [7:0] rx_byte,
    input  logic       rx_frame_start,
    input  logic       rx_oof,
    input  logic       descr_off,
    output logic [7:0] oh_data,
    output logic       oh_stb,
    output logic       oh_fp,
    output logic       b1_err
);
    pos_info_t  info;
    logic       active;
    logic [7:0] plain;

    soht_position #(.N_STS(N_STS)) u_pos (
        .clk(clk), .rst(rst), .frm_start(rx_frame_start), .oof(rx_oof),
        .info(info), .active(active)
    );

    soht_descrambler u_dsc (
        .clk(clk), .rst(rst), .din(rx_byte), .info(info),
        .bypass(descr_off), .dout(plain)
    );

    soht_bip8 u_bip (
        .clk(clk), .rst(rst), .raw(rx_byte), .plain(plain), .info(info),
        .active(active), .err_pulse(b1_err)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            oh_data <= '0;
            oh_stb  <= 1'b0;
            oh_fp   <= 1'b0;
        end else begin
            oh_stb <= active && info.tap;
            oh_fp  <= active && info.tap && info.frame_first;
            if (active && info.tap) oh_data <= plain;
        end
    end

    // R3: the frame marker only rides on a strobe.
    a_r3_fp_on_strobe: assert property (@(posedge clk) disable iff (rst)
        oh_fp |-> oh_stb);
    // R9: no overhead byte is exported for a byte seen while out-of-frame.
    a_r9_quiet_oof: assert property (@(posedge clk) disable iff (rst)
        rx_oof |=> !oh_stb);
    // R2: each strobe lasts a single cycle, because tap columns are never adjacent.
    a_r2_strobe_single: assert property (@(posedge clk) disable iff (rst)
        (oh_stb && !rx_frame_start) |=> !oh_stb);
endmodule

// File: tb/tb_sonet_oh_tap.sv
module tb_sonet_oh_tap;
    localparam int N      = 2;
    localparam int ROWLEN = 90 * N;
    localparam int FRAME  = 9 * ROWLEN;
    localparam int TOHL   = 3 * N;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] rx_byte = '0;
    logic       rx_frame_start = 1'b0;
    logic       rx_oof = 1'b0;
    logic       descr_off = 1'b0;
    logic [7:0] oh_data;
    logic       oh_stb, oh_fp, b1_err;

    sonet_oh_tap #(.N_STS(N)) dut (
        .clk(clk), .rst(rst), .rx_byte(rx_byte), .rx_frame_start(rx_frame_start),
        .rx_oof(rx_oof), .descr_off(descr_off), .oh_data(oh_data),
        .oh_stb(oh_stb), .oh_fp(oh_fp), .b1_err(b1_err)
    );

    always #2.5 clk = ~clk;

    int checks = 0, failures = 0;
    logic [7:0] ks [FRAME];
    logic [7:0] tx [FRAME];
    logic [7:0] pl [FRAME];
    logic [7:0] exp_oh [27];
    logic [7:0] cap_d [32];
    logic       cap_f [32];
    int cap_n = 0, pulse_n = 0, double_hi = 0, first_delay = -1;
    int cyc = 0, fp_cyc = 0;
    logic err_prev = 1'b0;
    logic [7:0] bip_prev = '0;

    task automatic check(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    always @(negedge clk) begin
        cyc++;
        if (oh_stb) begin
            if (cap_n < 32) begin
                cap_d[cap_n] = oh_data;
                cap_f[cap_n] = oh_fp;
            end
            cap_n++;
        end
        if (oh_fp) fp_cyc = cyc;
        if (b1_err && !err_prev) begin
            pulse_n++;
            if (first_delay < 0) first_delay = cyc - fp_cyc;
        end
        if (b1_err && err_prev) double_hi++;
        err_prev = b1_err;
    end

    // Keystream from the recurrence a[m] = a[m-7] ^ a[m-6], first seven bits one.
    initial begin
        logic [0:6] w;
        logic       b;
        w = '0;
        for (int j = 0; j < FRAME; j++) begin
            ks[j] = '0;
            for (int k = 0; k < 8; k++) begin
                b = (j*8 + k < 7) ? 1'b1 : (w[0] ^ w[1]);
                w = {w[1:6], b};
                ks[j][7-k] = b;
            end
        end
    end

    task automatic drive(input logic [7:0] d, input logic fs, input logic oof);
        @(negedge clk);
        rx_byte = d;
        rx_frame_start = fs;
        rx_oof = oof;
    endtask

    function automatic int popc(input logic [7:0] v);
        int n = 0;
        for (int i = 0; i < 8; i++) if (v[i]) n++;
        return n;
    endfunction

    task automatic build(input int fno, input logic [7:0] flip, input bit scr);
        int e = 0;
        for (int r = 0; r < 9; r++) begin
            for (int c = 0; c < ROWLEN; c++) begin
                int i = r*ROWLEN + c;
                pl[i] = 8'(i*37 + fno*11 + 5);
                if (r == 0 && c < N)                    pl[i] = 8'hF6;
                else if (r == 0 && c < 2*N)             pl[i] = 8'h28;
                else if (r == 0 && c < TOHL)            pl[i] = 8'h01;
                if (r == 1 && c == 0)                   pl[i] = bip_prev ^ flip;
                tx[i] = (scr && !(r == 0 && c < TOHL)) ? (pl[i] ^ ks[i - TOHL]) : pl[i];
                if (c == 0 || c == N || c == 2*N) begin
                    exp_oh[e] = pl[i];
                    e++;
                end
            end
        end
    endtask

    // Sends one frame and checks overhead export and the error pulse train.
    task automatic run_frame(input int fno, input logic [7:0] flip, input bit scr,
                             input int exp_pulses, input string tag);
        int mism = 0, fps = 0;
        logic [7:0] x = '0;
        build(fno, flip, scr);
        cap_n = 0; pulse_n = 0; double_hi = 0; first_delay = -1;
        for (int i = 0; i < FRAME; i++) drive(tx[i], i == 0, 1'b0);
        for (int i = 0; i < FRAME; i++) x ^= tx[i];
        bip_prev = x;
        check(cap_n == 27, {tag, " R2 strobe count"}, cap_n, 27);
        for (int i = 0; i < 27 && i < cap_n; i++) begin
            if (cap_d[i] !== exp_oh[i]) begin
                mism++;
                if (mism == 1)
                    $display("  byte %0d got %h want %h", i, cap_d[i], exp_oh[i]);
            end
            if (cap_f[i]) fps++;
        end
        check(mism == 0, {tag, " R2/R4/R5 overhead bytes"}, mism, 0);
        check(fps == 1 && cap_f[0] === 1'b1, {tag, " R3 frame marker"}, fps, 1);
        check(pulse_n == exp_pulses, {tag, " R6/R8 pulse count"}, pulse_n, exp_pulses);
        check(double_hi == 0, {tag, " R6 pulse width"}, double_hi, 0);
        if (exp_pulses > 0)
            check(first_delay == ROWLEN + 1, {tag, " R7 pulse delay"}, first_delay, ROWLEN + 1);
    endtask

    task automatic t_reset;
        repeat (3) @(negedge clk);
        check(!oh_stb && !oh_fp && !b1_err, "R1 outputs in reset", {oh_stb, oh_fp, b1_err}, 0);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(!oh_stb && !oh_fp && !b1_err, "R1 outputs after release", {oh_stb, oh_fp, b1_err}, 0);
    endtask

    task automatic t_clean;
        run_frame(1, 8'h5A, 1'b1, 0, "first-frame-unchecked R8");
        run_frame(2, 8'h00, 1'b1, 0, "clean R4");
        run_frame(3, 8'h00, 1'b1, 0, "clean R6");
    endtask

    task automatic t_errors;
        run_frame(4, 8'h01, 1'b1, popc(8'h01), "one-bit R6");
        run_frame(5, 8'h07, 1'b1, popc(8'h07), "three-bit R7");
        run_frame(6, 8'hFF, 1'b1, popc(8'hFF), "all-bits R6");
    endtask

    task automatic t_bypass;
        descr_off = 1'b1;
        run_frame(7, 8'h00, 1'b0, 0, "bypass R5");
        run_frame(8, 8'h81, 1'b0, 2, "bypass-err R5");
        descr_off = 1'b0;
    endtask

    task automatic t_oof;
        build(9, 8'h00, 1'b1);
        for (int i = 0; i < 100; i++) drive(tx[i], i == 0, 1'b0);
        cap_n = 0;
        for (int i = 0; i < 2*FRAME/3; i++) drive(8'h00, 1'b0, 1'b1);
        for (int i = 0; i < 300; i++) drive(8'h00, 1'b0, 1'b0);
        check(cap_n == 0, "R9 no strobes while out of frame", cap_n, 0);
        run_frame(10, 8'h3C, 1'b1, 0, "realign R8");
        run_frame(11, 8'h03, 1'b1, 2, "after-realign R6");
    endtask

    initial begin
        fork
            begin
                t_reset;
                t_clean;
                t_errors;
                t_bypass;
                t_oof;
            end
            begin
                repeat (100000) @(posedge clk);
                failures++;
                $display("FAIL watchdog expired");
            end
        join_any
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule